// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block gathers the event pulses of a multi-channel display controller into two status registers. Each status bit has its own mask bit. The block drives one level-sensitive interrupt line. Channel 0 keeps its start-of-frame, end-of-frame and branch flags in status register 0, next to the controller-wide flags. Channels 1 to 6 keep theirs in status register 1, and a dedicated mask register sits beside it.

Each channel event arrives with the frame identifier of that channel. An event that is not masked, arriving while the interrupt line is low, copies its frame identifier into an identifier register. Software can then tell which frame raised the interrupt. An unmasked event that arrives while the line is already high, or that loses a same-cycle tie, sets a secondary-interrupt flag instead. A bus error follows the same identifier and secondary rule without any mask. It also records the number of the failing channel. Software reads all registers through a small register port and clears status by writing ones.

Top module: `disp_irq_stat`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Status 0 (address 2) bit positions are as follows. Bits 0 to 12 are: last-frame-done `last_done_i`, channel 0 SOF, bus error, AC-bias `acb_i`, underrun 0 `urun0_i`, underrun 1 `urun1_i`, output underrun `ourun_i`, quick-disable, channel 0 EOF, channel 0 branch, secondary interrupt, read-status `rd_stat_i`, command-done `cmd_done_i`. Bits 30:28 hold a 3-bit bus-error channel number. Every event input sets its bit at the next clock edge.
- R3: For channel n from 1 to 6, status 1 (address 3) sets bit n-1 on SOF, bit n+7 on EOF and bit n+15 on branch. No other status 1 bit is ever set.
- R4: `irq_o` is high when any of the following pairs has its status bit set and its mask bit clear. Mask bits are in control register 0 (address 0) unless noted.
  - status0[0] with ctrl0[3]
  - status0[1] with ctrl0[4]
  - status0[4] with ctrl0[5]
  - status0[8] with ctrl0[6]
  - status0[7] with ctrl0[11]
  - status0[9] with ctrl0[20]
  - status0[6] with ctrl0[21]
  - status0[11] with ctrl0[23]
  - status0[12] with ctrl0[24]
  - status0[5] with mask5[24]
  - any status1[k] with mask5[k]

  The bus-error, AC-bias and secondary bits never drive `irq_o`. The line follows the registered state.
- R5: An unmasked SOF, EOF or branch event that arrives while `irq_o` is low loads that channel's `fid_i` word into the ID register (address 4). A masked event sets only its status bit. A masked event changes neither the ID register nor the secondary bit.
- R6: An unmasked event that arrives while `irq_o` is high sets status0[10]. The ID register keeps its value.
- R7: A bus error on channel c sets status0[2] and writes c into status0[30:28]. It applies the rule of R5 and R6 whatever the masks hold.
- R8: When several channels have qualifying events in one cycle and `irq_o` is low, the lowest channel number loads the ID register and status0[10] is set. When several bus errors arrive in one cycle, the lowest erroring channel goes into status0[30:28].
- R9: Writing status 0 clears the bits of status0[11:0] that are written as one. Writing bit 2 as one also clears bits 30:28. Bit 12 is never cleared by a write. An event in the same cycle as the write wins over the clear.
- R10: Writing status 1 clears only the written-one bits within 0x003E3F3F. All other status 1 bits, including channel 1 branch at bit 16, are left unchanged.
- R11: Control register 0 stores the written value ANDed with 0x07FFFFFF. The channel mask register (address 1) stores the written value ANDed with 0x3F3F3F3F.
- R12: A write to control register 0 that clears bit 0 while bit 0 was set raises status0[7].
- R13: Addresses 5 to 7 read zero. The ID register ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| sof_i | input | NCH | Start-of-frame pulse per channel |
| eof_i | input | NCH | End-of-frame pulse per channel |
| bra_i | input | NCH | Branch pulse per channel |
| berr_i | input | NCH | Bus-error pulse per channel |
| fid_i | input | NCH*FID_W | Frame ID per channel, channel c at [c*FID_W +: FID_W] |
| last_done_i | input | 1 | Last frame done pulse |
| acb_i | input | 1 | AC-bias count pulse |
| urun0_i | input | 1 | Input underrun 0 pulse |
| urun1_i | input | 1 | Input underrun 1 pulse |
| ourun_i | input | 1 | Output underrun pulse |
| rd_stat_i | input | 1 | Read-status pulse |
| cmd_done_i | input | 1 | Command-done pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle the following properties:
- the ID register holds while the line is high;
- a nonzero bus-error channel field never appears without the bus-error bit;
- the command-done bit is sticky;
- the reserved status 1 and mask bits stay zero;
- quick-disable follows a falling enable.

Only the bench scenarios can show the following behaviours:
- which channel wins a same-cycle tie;
- that a masked event leaves the ID and secondary bits alone;
- that an event beats a simultaneous clear;
- the exact interrupt level for each mask pair.

The cycle model compared on every clock covers the random mix of these behaviours.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam logic [2:0] A_CTRL0 = 3'd0;
  localparam logic [2:0] A_MASK5 = 3'd1;
  localparam logic [2:0] A_STAT0 = 3'd2;
  localparam logic [2:0] A_STAT1 = 3'd3;
  localparam logic [2:0] A_FID   = 3'd4;

  localparam logic [31:0] CTRL0_KEEP = 32'h07FF_FFFF;
  localparam logic [31:0] MASK5_KEEP = 32'h3F3F_3F3F;
  localparam logic [31:0] STAT0_W1C  = 32'h0000_0FFF;
  localparam logic [31:0] STAT1_W1C  = 32'h003E_3F3F;
  localparam logic [31:0] STAT1_USED = 32'h003F_3F3F;

  // status 0 layout
  localparam int S0_LDONE = 0;
  localparam int S0_SOF   = 1;
  localparam int S0_BERR  = 2;
  localparam int S0_ACB   = 3;
  localparam int S0_URUN0 = 4;
  localparam int S0_URUN1 = 5;
  localparam int S0_OURUN = 6;
  localparam int S0_QDIS  = 7;
  localparam int S0_EOF   = 8;
  localparam int S0_BRA   = 9;
  localparam int S0_SINT  = 10;
  localparam int S0_RDST  = 11;
  localparam int S0_CMD   = 12;
  localparam int S0_BCH_LO = 28;
  localparam int S0_BCH_HI = 30;

  // control 0 layout
  localparam int C0_EN      = 0;
  localparam int C0_M_LDONE = 3;
  localparam int C0_M_SOF   = 4;
  localparam int C0_M_URUN0 = 5;
  localparam int C0_M_EOF   = 6;
  localparam int C0_M_QDIS  = 11;
  localparam int C0_M_BRA   = 20;
  localparam int C0_M_OURUN = 21;
  localparam int C0_M_RDST  = 23;
  localparam int C0_M_CMD   = 24;

  // status 1 / mask 5: bit = base + ch - 1
  localparam int S1_SOF_BASE  = 0;
  localparam int S1_EOF_BASE  = 8;
  localparam int S1_BRA_BASE  = 16;
  localparam int S1_URUN_BASE = 24;
endpackage

// File: rtl/disp_irq_eval.sv
module disp_irq_eval
  import disp_irq_pkg::*;
(
  input  logic [31:0] ctrl0_i,
  input  logic [31:0] mask5_i,
  input  logic [12:0] stat0_i,
  input  logic [31:0] stat1_i,
  output logic        irq_o
);
  logic [12:0] s0_en;
  logic        s0_hit, s1_hit;

  always_comb begin
    s0_en = '0;
    s0_en[S0_LDONE] = ~ctrl0_i[C0_M_LDONE];
    s0_en[S0_SOF]   = ~ctrl0_i[C0_M_SOF];
    s0_en[S0_URUN0] = ~ctrl0_i[C0_M_URUN0];
    s0_en[S0_URUN1] = ~mask5_i[S1_URUN_BASE];
    s0_en[S0_OURUN] = ~ctrl0_i[C0_M_OURUN];
    s0_en[S0_QDIS]  = ~ctrl0_i[C0_M_QDIS];
    s0_en[S0_EOF]   = ~ctrl0_i[C0_M_EOF];
    s0_en[S0_BRA]   = ~ctrl0_i[C0_M_BRA];
    s0_en[S0_RDST]  = ~ctrl0_i[C0_M_RDST];
    s0_en[S0_CMD]   = ~ctrl0_i[C0_M_CMD];
  end

  assign s0_hit = |(stat0_i & s0_en);
  assign s1_hit = |(stat1_i & ~mask5_i);
  assign irq_o  = s0_hit | s1_hit;
endmodule

// File: rtl/disp_evt_arb.sv
module disp_evt_arb
  import disp_irq_pkg::*;
#(
  parameter int NCH   = 7,
  parameter int FID_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCH-1:0]       sof_i,
  input  logic [NCH-1:0]       eof_i,
  input  logic [NCH-1:0]       bra_i,
  input  logic [NCH-1:0]       berr_i,
  input  logic [NCH*FID_W-1:0] fid_i,
  input  logic [31:0]          ctrl0_i,
  input  logic [31:0]          mask5_i,
  input  logic                 irq_i,
  output logic [31:0]          set0_o,
  output logic [31:0]          set1_o,
  output logic                 bch_vld_o,
  output logic [2:0]           bch_o,
  output logic                 id_ld_o,
  output logic [FID_W-1:0]     id_o
);
  // NCH is limited to 7 by the 3-bit channel field and the status 1 layout
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] sof_m, eof_m, bra_m, hit;
  logic [CHW-1:0] win, bwin;
  logic           any_hit, multi, sint;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c == 0) begin : g_base
      assign sof_m[c] = ctrl0_i[C0_M_SOF];
      assign eof_m[c] = ctrl0_i[C0_M_EOF];
      assign bra_m[c] = ctrl0_i[C0_M_BRA];
    end else begin : g_ext
      assign sof_m[c] = mask5_i[S1_SOF_BASE + c - 1];
      assign eof_m[c] = mask5_i[S1_EOF_BASE + c - 1];
      assign bra_m[c] = mask5_i[S1_BRA_BASE + c - 1];
    end
  end

  // bus error bypasses masks
  assign hit     = (sof_i & ~sof_m) | (eof_i & ~eof_m) | (bra_i & ~bra_m) | berr_i;
  assign any_hit = |hit;
  assign multi   = |(hit & (hit - NCH'(1)));
  assign sint    = any_hit & (irq_i | multi);

  always_comb begin
    win = '0;
    for (int c = NCH - 1; c >= 0; c--) if (hit[c]) win = CHW'(c);
  end

  always_comb begin
    bwin = '0;
    for (int c = NCH - 1; c >= 0; c--) if (berr_i[c]) bwin = CHW'(c);
  end

  always_comb begin
    set0_o = '0;
    set0_o[S0_SOF]  = sof_i[0];
    set0_o[S0_EOF]  = eof_i[0];
    set0_o[S0_BRA]  = bra_i[0];
    set0_o[S0_BERR] = |berr_i;
    set0_o[S0_SINT] = sint;
  end

  always_comb begin
    set1_o = '0;
    for (int c = 1; c < NCH; c++) begin
      set1_o[S1_SOF_BASE + c - 1] = sof_i[c];
      set1_o[S1_EOF_BASE + c - 1] = eof_i[c];
      set1_o[S1_BRA_BASE + c - 1] = bra_i[c];
    end
  end

  assign bch_vld_o = |berr_i;
  assign bch_o     = 3'(bwin);
  assign id_ld_o   = any_hit & ~irq_i;
  assign id_o      = fid_i[win*FID_W +: FID_W];

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl0_i, mask5_i};

  AST_TIE_SINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_ld_o && multi) |-> set0_o[S0_SINT]); // R8
  AST_BUSY_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_hit && irq_i) |-> (!id_ld_o && set0_o[S0_SINT])); // R6
endmodule

// File: rtl/disp_status_regs.sv
module disp_status_regs
  import disp_irq_pkg::*;
#(
  parameter int FID_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [31:0]      set0_i,
  input  logic [31:0]      set1_i,
  input  logic             bch_vld_i,
  input  logic [2:0]       bch_i,
  input  logic             id_ld_i,
  input  logic [FID_W-1:0] id_i,
  output logic [31:0]      ctrl0_o,
  output logic [31:0]      mask5_o,
  output logic [31:0]      stat0_o,
  output logic [31:0]      stat1_o,
  output logic [FID_W-1:0] fid_o
);
  logic [31:0] ctrl0_q, mask5_q, stat0_q, stat1_q, stat0_d, stat1_d;
  logic [FID_W-1:0] fid_q;
  logic wr_ctrl0, wr_mask5, wr_stat0, wr_stat1, qd_evt;

  assign wr_ctrl0 = we_i && (addr_i == A_CTRL0);
  assign wr_mask5 = we_i && (addr_i == A_MASK5);
  assign wr_stat0 = we_i && (addr_i == A_STAT0);
  assign wr_stat1 = we_i && (addr_i == A_STAT1);
  assign qd_evt   = wr_ctrl0 && ctrl0_q[C0_EN] && !wdata_i[C0_EN];

  // clear first, then sets win
  always_comb begin
    stat0_d = stat0_q;
    if (wr_stat0) begin
      stat0_d = stat0_d & ~(wdata_i & STAT0_W1C);
      if (wdata_i[S0_BERR]) stat0_d[S0_BCH_HI:S0_BCH_LO] = '0;
    end
    stat0_d = stat0_d | set0_i;
    if (qd_evt)    stat0_d[S0_QDIS] = 1'b1;
    if (bch_vld_i) stat0_d[S0_BCH_HI:S0_BCH_LO] = bch_i;
  end

  always_comb begin
    stat1_d = stat1_q;
    if (wr_stat1) stat1_d = stat1_d & ~(wdata_i & STAT1_W1C);
    stat1_d = stat1_d | set1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_q <= '0;
      mask5_q <= '0;
      stat0_q <= '0;
      stat1_q <= '0;
      fid_q   <= '0;
    end else begin
      if (wr_ctrl0) ctrl0_q <= wdata_i & CTRL0_KEEP;
      if (wr_mask5) mask5_q <= wdata_i & MASK5_KEEP;
      stat0_q <= stat0_d;
      stat1_q <= stat1_d;
      if (id_ld_i) fid_q <= id_i;
    end
  end

  assign ctrl0_o = ctrl0_q;
  assign mask5_o = mask5_q;
  assign stat0_o = stat0_q;
  assign stat1_o = stat1_q;
  assign fid_o   = fid_q;

  AST_QD_ON_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qd_evt |=> stat0_q[S0_QDIS]); // R12
  AST_CMD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat0_q[S0_CMD] |=> stat0_q[S0_CMD]); // R9
  AST_BCH_WITH_BERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat0_q[S0_BCH_HI:S0_BCH_LO] != 3'd0) |-> stat0_q[S0_BERR]); // R7
  AST_MASK5_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask5_q & ~MASK5_KEEP) == 32'd0); // R11
  AST_S1_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat1_q & ~STAT1_USED) == 32'd0); // R3
endmodule

// File: rtl/disp_irq_stat.sv
module disp_irq_stat
  import disp_irq_pkg::*;
#(
  parameter int NCH   = 7,
  parameter int FID_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [2:0]           reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [NCH-1:0]       sof_i,
  input  logic [NCH-1:0]       eof_i,
  input  logic [NCH-1:0]       bra_i,
  input  logic [NCH-1:0]       berr_i,
  input  logic [NCH*FID_W-1:0] fid_i,
  input  logic                 last_done_i,
  input  logic                 acb_i,
  input  logic                 urun0_i,
  input  logic                 urun1_i,
  input  logic                 ourun_i,
  input  logic                 rd_stat_i,
  input  logic                 cmd_done_i,
  output logic                 irq_o
);
  logic [31:0] ctrl0, mask5, stat0, stat1, arb_set0, set0, set1, fid_ext;
  logic [FID_W-1:0] fid_q, id_val;
  logic bch_vld, id_ld, irq;
  logic [2:0] bch;

  disp_irq_eval u_eval (
    .ctrl0_i (ctrl0),
    .mask5_i (mask5),
    .stat0_i (stat0[12:0]),
    .stat1_i (stat1),
    .irq_o   (irq)
  );

  disp_evt_arb #(.NCH(NCH), .FID_W(FID_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sof_i     (sof_i),
    .eof_i     (eof_i),
    .bra_i     (bra_i),
    .berr_i    (berr_i),
    .fid_i     (fid_i),
    .ctrl0_i   (ctrl0),
    .mask5_i   (mask5),
    .irq_i     (irq),
    .set0_o    (arb_set0),
    .set1_o    (set1),
    .bch_vld_o (bch_vld),
    .bch_o     (bch),
    .id_ld_o   (id_ld),
    .id_o      (id_val)
  );

  always_comb begin
    set0 = arb_set0;
    set0[S0_LDONE] = arb_set0[S0_LDONE] | last_done_i;
    set0[S0_ACB]   = arb_set0[S0_ACB]   | acb_i;
    set0[S0_URUN0] = arb_set0[S0_URUN0] | urun0_i;
    set0[S0_URUN1] = arb_set0[S0_URUN1] | urun1_i;
    set0[S0_OURUN] = arb_set0[S0_OURUN] | ourun_i;
    set0[S0_RDST]  = arb_set0[S0_RDST]  | rd_stat_i;
    set0[S0_CMD]   = arb_set0[S0_CMD]   | cmd_done_i;
  end

  disp_status_regs #(.FID_W(FID_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .set0_i    (set0),
    .set1_i    (set1),
    .bch_vld_i (bch_vld),
    .bch_i     (bch),
    .id_ld_i   (id_ld),
    .id_i      (id_val),
    .ctrl0_o   (ctrl0),
    .mask5_o   (mask5),
    .stat0_o   (stat0),
    .stat1_o   (stat1),
    .fid_o     (fid_q)
  );

  always_comb begin
    fid_ext = '0;
    fid_ext[FID_W-1:0] = fid_q;
  end

  always_comb begin
    case (reg_addr_i)
      A_CTRL0: reg_rdata_o = ctrl0;
      A_MASK5: reg_rdata_o = mask5;
      A_STAT0: reg_rdata_o = stat0;
      A_STAT1: reg_rdata_o = stat1;
      A_FID:   reg_rdata_o = fid_ext;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = irq;

  AST_ID_FROZEN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |=> $stable(fid_q)); // R6
  AST_NO_IRQ_FROM_BERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat0[12:0] & ~13'h0404 & ~13'h0008) == 13'd0 && stat1 == 32'd0) |-> !irq_o); // R4
endmodule

// File: tb/sim_disp_irq_stat.sv
`timescale 1ns/100ps
module sim_disp_irq_stat;
  localparam int NCH = 7;
  localparam int FID_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic we = 0;
  logic [2:0] addr = 0;
  logic [31:0] wd = 0;
  logic [31:0] rd;
  logic [NCH-1:0] sof = 0, eof = 0, bra = 0, berr = 0;
  logic [FID_W-1:0] fid [NCH];
  logic [NCH*FID_W-1:0] fid_bus;
  logic ldone = 0, acb = 0, ur0 = 0, ur1 = 0, our = 0, rdst = 0, cmdd = 0;
  logic irq;

  always_comb for (int c = 0; c < NCH; c++) fid_bus[c*FID_W +: FID_W] = fid[c];

  disp_irq_stat #(.NCH(NCH), .FID_W(FID_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .sof_i(sof), .eof_i(eof),
    .bra_i(bra), .berr_i(berr), .fid_i(fid_bus), .last_done_i(ldone),
    .acb_i(acb), .urun0_i(ur0), .urun1_i(ur1), .ourun_i(our),
    .rd_stat_i(rdst), .cmd_done_i(cmdd), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_c0 = 0, m_m5 = 0, m_s0 = 0, m_s1 = 0, m_fid = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_irq();
    logic l;
    l = (m_s0[0] & ~m_c0[3]) | (m_s0[1] & ~m_c0[4]) | (m_s0[4] & ~m_c0[5]) |
        (m_s0[8] & ~m_c0[6]) | (m_s0[7] & ~m_c0[11]) | (m_s0[9] & ~m_c0[20]) |
        (m_s0[6] & ~m_c0[21]) | (m_s0[11] & ~m_c0[23]) | (m_s0[12] & ~m_c0[24]) |
        (m_s0[5] & ~m_m5[24]);
    l = l | (|(m_s1 & ~m_m5));
    return l;
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_c0;
      3'd1: return m_m5;
      3'd2: return m_s0;
      3'd3: return m_s1;
      3'd4: return m_fid;
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_step();
    logic pre, u;
    logic [31:0] n0, n1, nc, nm;
    int first, nhit, bfirst;
    pre = m_irq(); n0 = m_s0; n1 = m_s1; nc = m_c0; nm = m_m5;
    first = -1; nhit = 0; bfirst = -1;
    if (we && addr == 3'd2) begin
      n0 = n0 & ~(wd & 32'hFFF);
      if (wd[2]) n0[30:28] = 3'd0;
    end
    if (we && addr == 3'd3) n1 = n1 & ~(wd & 32'h003E3F3F);
    if (we && addr == 3'd0) begin
      nc = wd & 32'h07FFFFFF;
      if (m_c0[0] && !wd[0]) n0[7] = 1'b1;
    end
    if (we && addr == 3'd1) nm = wd & 32'h3F3F3F3F;
    for (int c = 0; c < NCH; c++) begin
      u = 0;
      if (sof[c]) begin
        if (c == 0) begin n0[1] = 1; if (!m_c0[4]) u = 1; end
        else begin n1[c-1] = 1; if (!m_m5[c-1]) u = 1; end
      end
      if (eof[c]) begin
        if (c == 0) begin n0[8] = 1; if (!m_c0[6]) u = 1; end
        else begin n1[c+7] = 1; if (!m_m5[c+7]) u = 1; end
      end
      if (bra[c]) begin
        if (c == 0) begin n0[9] = 1; if (!m_c0[20]) u = 1; end
        else begin n1[c+15] = 1; if (!m_m5[c+15]) u = 1; end
      end
      if (berr[c]) begin n0[2] = 1; u = 1; if (bfirst < 0) bfirst = c; end
      if (u) begin nhit++; if (first < 0) first = c; end
    end
    if (ldone) n0[0] = 1;
    if (acb) n0[3] = 1;
    if (ur0) n0[4] = 1;
    if (ur1) n0[5] = 1;
    if (our) n0[6] = 1;
    if (rdst) n0[11] = 1;
    if (cmdd) n0[12] = 1;
    if (bfirst >= 0) n0[30:28] = 3'(bfirst);
    if (nhit > 0) begin
      if (pre) n0[10] = 1;
      else begin
        m_fid = fid[first];
        if (nhit > 1) n0[10] = 1;
      end
    end
    m_s0 = n0; m_s1 = n1; m_c0 = nc; m_m5 = nm;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c0 = 0; m_m5 = 0; m_s0 = 0; m_s1 = 0; m_fid = 0;
    end else m_step();
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 irq level vs model", {31'd0, irq}, {31'd0, m_irq()});
      chk("R13 readback vs model", rd, m_read(addr));
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    sof = 0; eof = 0; bra = 0; berr = 0; we = 0;
    ldone = 0; acb = 0; ur0 = 0; ur1 = 0; our = 0; rdst = 0; cmdd = 0;
  endtask

  task automatic pulse();
    cyc();
    idle();
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    we = 1; addr = a; wd = d;
    pulse();
  endtask

  task automatic rdchk(logic [2:0] a, logic [31:0] exp, string tag);
    addr = a;
    #1;
    chk(tag, rd, exp);
    cyc();
  endtask

  task automatic irqchk(logic exp, string tag);
    #1;
    chk(tag, {31'd0, irq}, {31'd0, exp});
    cyc();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) fid[c] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    // R1 reset state
    rdchk(3'd0, 32'h0, "R1 ctrl0 reset");
    rdchk(3'd1, 32'h0, "R1 mask5 reset");
    rdchk(3'd2, 32'h0, "R1 stat0 reset");
    rdchk(3'd3, 32'h0, "R1 stat1 reset");
    rdchk(3'd4, 32'h0, "R1 fid reset");
    irqchk(1'b0, "R1 irq reset");
    // R11 write masks
    wr(3'd0, 32'hFFFF_FFFF);
    rdchk(3'd0, 32'h07FF_FFFF, "R11 ctrl0 keep");
    wr(3'd1, 32'hFFFF_FFFF);
    rdchk(3'd1, 32'h3F3F_3F3F, "R11 mask5 keep");
    // R12 quick disable
    wr(3'd0, 32'h0);
    rdchk(3'd2, 32'h80, "R12 quick disable");
    irqchk(1'b1, "R4 qd unmasked");
    wr(3'd2, 32'h80);
    irqchk(1'b0, "R9 qd cleared");
    wr(3'd1, 32'h0);
    // R2 misc sources
    ldone = 1; acb = 1; ur0 = 1; ur1 = 1; our = 1; rdst = 1;
    pulse();
    rdchk(3'd2, 32'h879, "R2 misc bits");
    irqchk(1'b1, "R4 misc irq");
    wr(3'd2, 32'hFFF);
    rdchk(3'd2, 32'h0, "R9 w1c all");
    // R5 first event loads id
    fid[0] = 32'h11; sof[0] = 1;
    pulse();
    rdchk(3'd4, 32'h11, "R5 id load");
    rdchk(3'd2, 32'h2, "R2 sof ch0 bit");
    irqchk(1'b1, "R4 sof irq");
    // R6 event while high
    fid[3] = 32'h33; eof[3] = 1;
    pulse();
    rdchk(3'd4, 32'h11, "R6 id kept");
    rdchk(3'd2, 32'h402, "R6 sint set");
    rdchk(3'd3, 32'h400, "R3 eof ch3 bit");
    wr(3'd2, 32'hFFF);
    wr(3'd3, 32'h003E3F3F);
    rdchk(3'd3, 32'h0, "R10 stat1 clear");
    irqchk(1'b0, "R4 idle");
    // R5 masked event
    wr(3'd1, 32'h2);
    fid[2] = 32'h22; sof[2] = 1;
    pulse();
    rdchk(3'd3, 32'h2, "R5 masked status set");
    rdchk(3'd4, 32'h11, "R5 masked id untouched");
    rdchk(3'd2, 32'h0, "R5 masked no sint");
    irqchk(1'b0, "R4 masked no irq");
    wr(3'd3, 32'h2);
    wr(3'd1, 32'h0);
    // R8 tie
    fid[4] = 32'h44; fid[2] = 32'h2B; sof[4] = 1; bra[2] = 1;
    pulse();
    rdchk(3'd4, 32'h2B, "R8 lowest wins");
    rdchk(3'd2, 32'h400, "R8 loser sint");
    rdchk(3'd3, 32'h20008, "R3 sof4 bra2 bits");
    wr(3'd3, 32'h003E3F3F);
    wr(3'd2, 32'hFFF);
    // R9 set beats clear
    fid[0] = 32'h55; sof[0] = 1; we = 1; addr = 3'd2; wd = 32'h2;
    pulse();
    rdchk(3'd2, 32'h2, "R9 event beats clear");
    rdchk(3'd4, 32'h55, "R5 id ch0");
    wr(3'd2, 32'h2);
    irqchk(1'b0, "R9 cleared");
    // R7 bus error with all masks set
    wr(3'd0, 32'h07FF_FFFE);
    wr(3'd1, 32'h3F3F_3F3F);
    fid[5] = 32'h5A; fid[6] = 32'h6A; berr[5] = 1; berr[6] = 1;
    pulse();
    rdchk(3'd2, 32'h5000_0404, "R7 berr field and sint");
    rdchk(3'd4, 32'h5A, "R7 berr id ignores masks");
    wr(3'd2, 32'h4);
    rdchk(3'd2, 32'h400, "R9 bit2 clears field");
    wr(3'd2, 32'hFFF);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    fid[1] = 32'h1A; berr[1] = 1;
    pulse();
    rdchk(3'd2, 32'h1000_0004, "R7 berr ch1");
    irqchk(1'b0, "R4 berr no irq");
    rdchk(3'd4, 32'h1A, "R7 berr id");
    wr(3'd2, 32'hFFF);
    // R9 cmd sticky
    cmdd = 1;
    pulse();
    irqchk(1'b1, "R4 cmd irq");
    wr(3'd2, 32'hFFF);
    rdchk(3'd2, 32'h1000, "R9 bit12 not cleared");
    wr(3'd0, 32'h0100_0000);
    irqchk(1'b0, "R4 cmd masked");
    // underrun 1 masked by mask5 bit 24
    wr(3'd1, 32'h0100_0000);
    ur1 = 1;
    pulse();
    rdchk(3'd2, 32'h1020, "R2 urun1 bit");
    irqchk(1'b0, "R4 urun1 masked");
    wr(3'd2, 32'h20);
    wr(3'd1, 32'h0);
    // R10 bit16 not clearable
    fid[1] = 32'h1B; bra[1] = 1;
    pulse();
    rdchk(3'd3, 32'h10000, "R3 bra ch1 bit");
    rdchk(3'd4, 32'h1B, "R5 id bra ch1");
    wr(3'd3, 32'hFFFF_FFFF);
    rdchk(3'd3, 32'h10000, "R10 bit16 kept");
    irqchk(1'b1, "R4 stat1 irq");
    wr(3'd1, 32'h0001_0000);
    irqchk(1'b0, "R4 stat1 masked");
    // R13 map
    rdchk(3'd5, 32'h0, "R13 unused addr");
    wr(3'd4, 32'hDEAD_BEEF);
    rdchk(3'd4, 32'h1B, "R13 id read only");
    // random traffic, compared against the model each cycle
    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < NCH; c++) fid[c] = $urandom;
      if ($urandom % 4 == 0) sof = NCH'($urandom);
      if ($urandom % 4 == 0) eof = NCH'($urandom);
      if ($urandom % 5 == 0) bra = NCH'($urandom);
      if ($urandom % 9 == 0) berr = NCH'($urandom);
      ldone = ($urandom % 11 == 0); ur0 = ($urandom % 13 == 0);
      ur1 = ($urandom % 13 == 0); our = ($urandom % 17 == 0);
      rdst = ($urandom % 19 == 0); acb = ($urandom % 19 == 0);
      if ($urandom % 3 == 0) begin
        we = 1; addr = 3'($urandom); wd = $urandom;
        if ($urandom % 2 == 0) begin addr = 3'd2; wd = 32'h0000_0FFF; end
      end else addr = 3'($urandom);
      pulse();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule